// File: doc/BRIEF.md
# Two-Channel Output Fault Guard

This block supervises two amplifier output stages against over-current and a single die-wide over-temperature condition. Each channel owns a small state machine that drives the stage while it is enabled, drops it on a short-circuit detect and then probes it again on a fixed microsecond period until the short has gone. A deglitched thermal trip removes drive from both channels while it lasts and gives it back by itself once the trip clears. Three sticky status flags, one per channel for over-current and one for thermal, record what happened and stay set until software writes a 0 to the matching bit.

Each channel state machine has four states. CH_IDLE means not permitted to drive. CH_RUN means driving normally. CH_BACKOFF means the stage is off and the retry counter is running. CH_PROBE means driving for one tick window as a retry. The transitions are as follows. Any state goes to CH_IDLE when the channel gate falls; the gate is the channel enable, with software shutdown clear and no live thermal trip. CH_IDLE goes to CH_RUN when the gate rises. CH_RUN goes to CH_BACKOFF on a short detect. CH_BACKOFF goes to CH_PROBE when the retry count expires. At the next tick, CH_PROBE goes back to CH_BACKOFF if the short is still present, and to CH_RUN if it is not.

Time is measured in ticks of one microsecond, produced from the system clock by dividing it by a parameter.

Top module: `amp_fault_guard`

## Requirements
- R1: With software shutdown clear and no thermal trip, a channel drives (drive_on bit high) within two clocks of its enable bit being 1, and stops driving when the enable bit is 0.
- R2: A short detect on a channel that is driving turns that channel's drive off on the next clock and raises its retry_mode bit. The other channel is not affected.
- R3: A short detect on a driving channel sets that channel's over-current flag (flag_oc bit 0 is the left channel, bit 1 is the right channel).
- R4: An over-current flag stays at 1 after the channel has recovered to normal drive, until it is cleared by a write.
- R5: After a short, the channel stays off for between (RETRY_US-1)*CLK_PER_US+1 and RETRY_US*CLK_PER_US clocks. It then drives for exactly one tick window (CLK_PER_US clocks) with retry_mode still high.
- R6: If the short is absent at the tick that ends the probe window, the channel returns to normal drive and retry_mode falls. If the short is present at that tick, the channel goes off again and retries on the same period, for as long as the short lasts.
- R7: While sw_shutdown is 1, no channel drives.
- R8: A raw thermal trip shorter than DEGLITCH_TICKS consecutive ticks neither sets the thermal flag nor removes drive.
- R9: A raw thermal trip held for DEGLITCH_TICKS consecutive ticks sets flag_therm and removes drive from both channels. Drive returns without software action once the raw trip falls, and flag_therm stays at 1.
- R10: A flag write (flag_wr high) clears each flag whose data bit is 0. The data bits are: bit 0 left over-current, bit 1 right over-current, bit 2 thermal. A data bit of 1 leaves its flag unchanged.
- R11: A new event in the same clock as a clearing write of its flag leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_shutdown | input | 1 | Software shutdown; 1 disables all drive |
| ch_enable | input | 2 | Per-channel enable (bit 0 left, bit 1 right) |
| short_det | input | 2 | Per-channel short-circuit detect |
| therm_raw | input | 1 | Raw, undeglitched over-temperature trip |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 3 | Flag write data; a 0 clears the flag in that bit position |
| drive_on | output | 2 | Per-channel output stage active |
| retry_mode | output | 2 | Per-channel low-duty retry indication |
| flag_oc | output | 2 | Sticky over-current flags |
| flag_therm | output | 1 | Sticky thermal flag |

## Verification
The bench builds the block with CLK_PER_US=4, RETRY_US=5 and DEGLITCH_TICKS=3. With these values a full back-off and probe cycle lasts about twenty clocks, and a thermal trip is qualified within a dozen. This lets the bench measure the exact off window and probe window, repeat a probe against a short that stays present, and tell a short thermal glitch from a qualified trip. The tick phase is unknown to the bench, so the off window is checked against the range that a free-running tick allows. The probe width does not depend on the tick phase and is checked exactly.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_BACKOFF = 2'd2,
        CH_PROBE   = 2'd3
    } ch_state_t;

    localparam int NUM_CH      = 2;
    localparam int FLAG_BITS   = NUM_CH + 1;
    localparam int THERM_BIT   = NUM_CH;
endpackage

// File: rtl/fg_tick_gen.sv
module fg_tick_gen #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [TW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == TW'(CLK_PER_US - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == TW'(CLK_PER_US - 1));
endmodule

// File: rtl/fg_therm_filter.sv
module fg_therm_filter #(
    parameter int DEGLITCH_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic therm_raw,
    output logic therm_live,
    output logic therm_evt
);
    localparam int DW = $clog2(DEGLITCH_TICKS + 1);

    logic [DW-1:0] run_q;
    logic          live_q;

    assign therm_evt  = therm_raw && tick && !live_q &&
                        (run_q == DW'(DEGLITCH_TICKS - 1));
    assign therm_live = live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            live_q <= 1'b0;
        end else if (!therm_raw) begin
            run_q  <= '0;
            live_q <= 1'b0;
        end else if (therm_evt) begin
            live_q <= 1'b1;
        end else if (tick && !live_q) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R8: a trip never stays live once the raw input has dropped
    assert_live_needs_raw_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !therm_raw |=> !therm_live
    ) else $error("live thermal trip without raw input");
endmodule

// File: rtl/fg_channel_fsm.sv
module fg_channel_fsm
    import fault_guard_pkg::*;
#(
    parameter int RETRY_US = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic gate,
    input  logic short_det,
    output logic drive_on,
    output logic retry_mode,
    output logic oc_evt
);
    localparam int CW = (RETRY_US > 1) ? $clog2(RETRY_US) : 1;

    ch_state_t     state_q, state_d;
    logic [CW-1:0] wait_q, wait_d;
    logic          wait_done;

    assign wait_done = tick && (wait_q == CW'(RETRY_US - 1));

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        if (!gate) begin
            state_d = CH_IDLE;
            wait_d  = '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    state_d = CH_RUN;
                end
                CH_RUN: begin
                    if (short_det) begin
                        state_d = CH_BACKOFF;
                        wait_d  = '0;
                    end
                end
                CH_BACKOFF: begin
                    if (wait_done) begin
                        state_d = CH_PROBE;
                        wait_d  = '0;
                    end else if (tick) begin
                        wait_d = wait_q + 1'b1;
                    end
                end
                CH_PROBE: begin
                    if (tick) begin
                        state_d = short_det ? CH_BACKOFF : CH_RUN;
                        wait_d  = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    always_comb begin
        drive_on   = 1'b0;
        retry_mode = 1'b0;
        unique case (state_q)
            CH_IDLE:    begin drive_on = 1'b0; retry_mode = 1'b0; end
            CH_RUN:     begin drive_on = gate; retry_mode = 1'b0; end
            CH_BACKOFF: begin drive_on = 1'b0; retry_mode = gate; end
            CH_PROBE:   begin drive_on = gate; retry_mode = gate; end
        endcase
        oc_evt = drive_on && short_det;
    end

    // R7: a closed gate always parks the channel in idle
    assert_gate_idle_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !gate |=> (state_q == CH_IDLE)
    ) else $error("channel not idle after gate closed");

    // R2: a short while running leads to back-off
    assert_short_backoff_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && gate && short_det) |=> (state_q == CH_BACKOFF)
    ) else $error("short did not start back-off");

    // R5: back-off is only left on a tick or a gate drop
    assert_backoff_holds_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == CH_BACKOFF && gate && !tick) |=> (state_q == CH_BACKOFF)
    ) else $error("back-off left between ticks");

    // R6: a probe that still sees the short returns to back-off
    assert_probe_fail_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == CH_PROBE && gate && tick && short_det) |=> (state_q == CH_BACKOFF)
    ) else $error("failed probe did not return to back-off");
endmodule

// File: rtl/amp_fault_guard.sv
module amp_fault_guard
    import fault_guard_pkg::*;
#(
    parameter int CLK_PER_US     = 100,
    parameter int RETRY_US       = 110,
    parameter int DEGLITCH_TICKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_shutdown,
    input  logic [NUM_CH-1:0]    ch_enable,
    input  logic [NUM_CH-1:0]    short_det,
    input  logic                 therm_raw,
    input  logic                 flag_wr,
    input  logic [FLAG_BITS-1:0] flag_wdata,
    output logic [NUM_CH-1:0]    drive_on,
    output logic [NUM_CH-1:0]    retry_mode,
    output logic [NUM_CH-1:0]    flag_oc,
    output logic                 flag_therm
);
    logic              tick;
    logic              therm_live;
    logic              therm_evt;
    logic [NUM_CH-1:0] gate;
    logic [NUM_CH-1:0] oc_evt;
    logic [NUM_CH-1:0] oc_q;
    logic              therm_q;

    fg_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    fg_therm_filter #(.DEGLITCH_TICKS(DEGLITCH_TICKS)) u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .therm_raw (therm_raw),
        .therm_live(therm_live),
        .therm_evt (therm_evt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign gate[c] = ch_enable[c] && !sw_shutdown && !therm_live;

        fg_channel_fsm #(.RETRY_US(RETRY_US)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .gate      (gate[c]),
            .short_det (short_det[c]),
            .drive_on  (drive_on[c]),
            .retry_mode(retry_mode[c]),
            .oc_evt    (oc_evt[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oc_q[c] <= 1'b0;
            end else if (oc_evt[c]) begin
                oc_q[c] <= 1'b1;
            end else if (flag_wr && !flag_wdata[c]) begin
                oc_q[c] <= 1'b0;
            end
        end

        // R4: a set flag survives every cycle that carries no clearing write
        assert_oc_sticky_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            (oc_q[c] && !(flag_wr && !flag_wdata[c])) |=> oc_q[c]
        ) else $error("over-current flag lost without a clear");
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm_q <= 1'b0;
        end else if (therm_evt) begin
            therm_q <= 1'b1;
        end else if (flag_wr && !flag_wdata[THERM_BIT]) begin
            therm_q <= 1'b0;
        end
    end

    // R9: while the trip is live neither channel drives
    assert_therm_blocks_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        therm_live |-> (drive_on == '0)
    ) else $error("drive active during thermal trip");

    assign flag_oc    = oc_q;
    assign flag_therm = therm_q;
endmodule

// File: tb/sim_amp_fault_guard.sv
module sim_amp_fault_guard;
    localparam int K   = 4;
    localparam int RT  = 5;
    localparam int DG  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_shutdown = 1'b0;
    logic [1:0] ch_enable = 2'b00;
    logic [1:0] short_det = 2'b00;
    logic       therm_raw = 1'b0;
    logic       flag_wr = 1'b0;
    logic [2:0] flag_wdata = 3'b111;
    logic [1:0] drive_on, retry_mode, flag_oc;
    logic       flag_therm;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    amp_fault_guard #(.CLK_PER_US(K), .RETRY_US(RT), .DEGLITCH_TICKS(DG)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_shutdown(sw_shutdown),
        .ch_enable(ch_enable), .short_det(short_det), .therm_raw(therm_raw),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .drive_on(drive_on),
        .retry_mode(retry_mode), .flag_oc(flag_oc), .flag_therm(flag_therm)
    );

    // vector fields: {sw_shutdown, ch_enable[1:0], expected drive_on[1:0]}
    localparam logic [4:0] VEC [6] = '{
        5'b0_00_00, 5'b0_01_01, 5'b0_10_10,
        5'b0_11_11, 5'b1_11_00, 5'b0_11_11
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int off_cnt;
        int on_cnt;
        step(3);
        rst_n = 1'b1;
        step(1);
        // reset state
        check(drive_on == 2'b00, "R1 reset drive", int'(drive_on), 0);
        check(retry_mode == 2'b00 && flag_oc == 2'b00 && !flag_therm,
              "R3 reset flags", int'({flag_therm, flag_oc, retry_mode}), 0);

        // R1 / R7 gating table
        for (int i = 0; i < 6; i++) begin
            sw_shutdown = VEC[i][4];
            ch_enable   = VEC[i][3:2];
            step(3);
            check(drive_on == VEC[i][1:0], VEC[i][4] ? "R7 shutdown" : "R1 enable",
                  int'(drive_on), int'(VEC[i][1:0]));
        end

        // R2 / R3: short pulse on left
        short_det = 2'b01;
        step(1);
        short_det = 2'b00;
        check(drive_on == 2'b10, "R2 left off right on", int'(drive_on), 2);
        check(retry_mode == 2'b01, "R2 retry_mode", int'(retry_mode), 1);
        check(flag_oc == 2'b01, "R3 left flag", int'(flag_oc), 1);

        // R5: off window then probe window
        off_cnt = 1;
        while (!drive_on[0]) begin step(1); if (!drive_on[0]) off_cnt++; end
        check(off_cnt >= (RT-1)*K+1 && off_cnt <= RT*K, "R5 off window", off_cnt, RT*K);
        on_cnt = 0;
        while (retry_mode[0] && drive_on[0]) begin on_cnt++; step(1); end
        check(on_cnt == K, "R5 probe width", on_cnt, K);
        // R6 recovered
        check(drive_on[0] && !retry_mode[0], "R6 recover", int'({drive_on[0], retry_mode[0]}), 2);
        step(2 * K);
        check(flag_oc[0], "R4 flag held after recovery", int'(flag_oc[0]), 1);

        // R10: write ones has no effect, write zero clears
        flag_wr = 1'b1; flag_wdata = 3'b111;
        step(1);
        flag_wr = 1'b0;
        check(flag_oc == 2'b01, "R10 write one ignored", int'(flag_oc), 1);
        flag_wr = 1'b1; flag_wdata = 3'b110;
        step(1);
        flag_wr = 1'b0; flag_wdata = 3'b111;
        check(flag_oc == 2'b00, "R10 write zero clears", int'(flag_oc), 0);

        // R11: event and clear in the same cycle
        flag_wr = 1'b1; flag_wdata = 3'b110; short_det = 2'b01;
        step(1);
        flag_wr = 1'b0; flag_wdata = 3'b111; short_det = 2'b00;
        check(flag_oc[0], "R11 event beats clear", int'(flag_oc[0]), 1);

        // R6: persistent short on right retries repeatedly
        short_det = 2'b10;
        step(1);
        check(!drive_on[1] && retry_mode[1], "R6 right backoff",
              int'({drive_on[1], retry_mode[1]}), 1);
        for (int p = 0; p < 2; p++) begin
            while (!drive_on[1]) step(1);
            on_cnt = 0;
            while (drive_on[1]) begin on_cnt++; step(1); end
            check(on_cnt == K, "R6 repeated probe width", on_cnt, K);
            check(retry_mode[1], "R6 still retrying", int'(retry_mode[1]), 1);
        end
        short_det = 2'b00;
        while (retry_mode != 2'b00) step(1);
        check(drive_on == 2'b11, "R6 both driving", int'(drive_on), 3);

        // R8: short thermal glitch
        therm_raw = 1'b1;
        step(2 * K);
        therm_raw = 1'b0;
        step(2);
        check(!flag_therm && drive_on == 2'b11, "R8 glitch ignored",
              int'({flag_therm, drive_on}), 3);

        // R9: qualified trip
        therm_raw = 1'b1;
        step((DG + 2) * K);
        check(flag_therm, "R9 thermal flag", int'(flag_therm), 1);
        check(drive_on == 2'b00, "R9 drive removed", int'(drive_on), 0);
        therm_raw = 1'b0;
        step(3);
        check(drive_on == 2'b11, "R9 drive returns", int'(drive_on), 3);
        check(flag_therm, "R9 flag stays", int'(flag_therm), 1);
        flag_wr = 1'b1; flag_wdata = 3'b011;
        step(1);
        flag_wr = 1'b0; flag_wdata = 3'b111;
        check(!flag_therm && flag_oc == 2'b11, "R10 thermal clear only",
              int'({flag_therm, flag_oc}), 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule